// File: doc/BRIEF.md
# Three-Phase Scan Self-Test Session Sequencer

This block runs one self-test session for a full-scan circuit. A start pulse launches three phases that always follow one another in the same order: a pseudorandom phase in which the pattern generator feeds the scan input directly, a semirandom phase in which stored sequences with sparse bit flips are selected, and a deterministic phase. The block drives the two select lines of the pattern-source multiplexers. It counts shift cycles so that each pattern is exactly one scan-chain length long. It inserts a one-cycle capture after every pattern and counts patterns per phase.

In the reseeding variant, each deterministic pattern is preceded by a wait for a seed on a valid/ready port. The accepted seed is passed to the pattern generator together with a one-cycle load strobe, and the generator output then goes to the scan input directly. In the other variant, the deterministic phase selects the decoded stored-sequence path instead. When the last deterministic pattern has been captured, a done flag rises and stays high until the next start.

Top module: `scan_bist_sequencer`

## Requirements
- R1: While reset is held, and after it is released with no start, `phase_o` is 0, `done_o` is 0, and `scan_en_o`, `capture_o`, `last_shift_o`, `seed_ready_o`, `seed_load_o`, `sel_random_o` and `sel_flip_o` are all 0.
- R2: After a start pulse, the session runs PRAND_PATS patterns with `phase_o`=1, then SEMI_PATS patterns with `phase_o`=2, then DET_PATS patterns with `phase_o`=3, and then returns to `phase_o`=0. The phase never moves backwards or skips a phase.
- R3: During phase 1, `sel_random_o`=0 and `sel_flip_o`=0.
- R4: During phase 2, `sel_random_o`=1 and `sel_flip_o`=0.
- R5: During phase 3, both selects are 0 when RESEED=1, and both selects are 1 when RESEED=0.
- R6: Every pattern is made of exactly SCAN_LEN consecutive cycles with `scan_en_o`=1. `last_shift_o` is 1 only in the final one of those cycles.
- R7: Each pattern's last shift cycle is followed by exactly one cycle with `capture_o`=1 and `scan_en_o`=0. The next pattern, or the seed wait, begins in the following cycle.
- R8: With RESEED=1, every phase-3 pattern is preceded by a wait with `seed_ready_o`=1 and no shifting, for as long as `seed_valid_i` is low. The handshake cycle raises `seed_load_o` for one cycle with `seed_o` equal to `seed_data_i`. Shifting starts in the next cycle, and there is exactly one load per deterministic pattern.
- R9: `done_o` rises in the cycle after the last phase-3 capture. It stays high until a start pulse, and it is 0 in the cycle after that start is taken.
- R10: A start pulse that arrives while a session is running has no effect on the pattern sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Session start pulse, taken only when idle |
| seed_valid_i | input | 1 | Seed offered |
| seed_data_i | input | SEED_W | Seed value |
| seed_ready_o | output | 1 | Sequencer waiting for a seed |
| seed_load_o | output | 1 | One-cycle seed load strobe to the pattern generator |
| seed_o | output | SEED_W | Seed value presented with the strobe |
| phase_o | output | 2 | 0 idle, 1 pseudorandom, 2 semirandom, 3 deterministic |
| sel_random_o | output | 1 | Source select: 1 picks the stored-sequence path |
| sel_flip_o | output | 1 | Flip select: 1 picks the decoded flip path |
| scan_en_o | output | 1 | Shift enable for the scan chain |
| last_shift_o | output | 1 | Marks the final shift cycle of a pattern |
| capture_o | output | 1 | One-cycle capture strobe |
| done_o | output | 1 | Session finished, held until the next start |

## Verification
The bench runs a reseeding instance through two sessions. In the first, seeds are offered as soon as they are requested, which shows the minimum-length sequence and the phase-to-select mapping. In the second, every seed is withheld for several cycles and a stray start pulse is given mid-session. This separates a design that keeps shifting without a seed, or that restarts, from one that stalls cleanly and ignores the extra pulse. A second instance without reseeding shares the scoreboard idea and tells apart the two phase-3 select encodings. Across every pattern, the shift count per capture catches off-by-one errors in the bit counter.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRAND = 2'd1,
    PH_SEMI  = 2'd2,
    PH_DET   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEED  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_CAPT  = 2'd3
  } step_e;
endpackage

// File: rtl/bist_bit_counter.sv
module bist_bit_counter #(
  parameter int SCAN_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  output logic shift_last
);
  localparam int BIT_W = $clog2(SCAN_LEN + 1);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(SCAN_LEN - 1);

  logic [BIT_W-1:0] cnt_q, cnt_d;

  assign shift_last = shift_en && (cnt_q == LAST_IDX);

  always_comb begin
    cnt_d = cnt_q;
    if (shift_en) begin
      if (shift_last) cnt_d = '0;
      else            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (shift_en) cnt_q <= cnt_d;
  end

  // R6: count stays inside one scan length
  assert_bitcnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX);
  // R6: an idle counter sits at zero so each pattern starts fresh
  assert_bitcnt_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && $past(shift_last)) |-> (cnt_q == '0));
endmodule

// File: rtl/bist_pat_counter.sv
module bist_pat_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             pat_last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign pat_last = (cnt_q == limit - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  // R2: a pattern is never counted past the phase quota
  assert_pat_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (cnt_q < limit));
endmodule

// File: rtl/bist_src_select.sv
module bist_src_select
  import bist_seq_pkg::*;
#(
  parameter bit RESEED = 1'b1
) (
  input  phase_e phase,
  output logic   sel_random,
  output logic   sel_flip
);
  generate
    if (RESEED) begin : g_reseed
      always_comb begin
        sel_random = (phase == PH_SEMI);
        sel_flip   = 1'b0;
      end
    end else begin : g_stored
      always_comb begin
        sel_random = (phase == PH_SEMI) || (phase == PH_DET);
        sel_flip   = (phase == PH_DET);
      end
    end
  endgenerate
endmodule

// File: rtl/scan_bist_sequencer.sv
module scan_bist_sequencer
  import bist_seq_pkg::*;
#(
  parameter int SCAN_LEN   = 64,
  parameter int PRAND_PATS = 10000,
  parameter int SEMI_PATS  = 10000,
  parameter int DET_PATS   = 16,
  parameter int SEED_W     = 20,
  parameter bit RESEED     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              seed_valid_i,
  input  logic [SEED_W-1:0] seed_data_i,
  output logic              seed_ready_o,
  output logic              seed_load_o,
  output logic [SEED_W-1:0] seed_o,
  output logic [1:0]        phase_o,
  output logic              sel_random_o,
  output logic              sel_flip_o,
  output logic              scan_en_o,
  output logic              last_shift_o,
  output logic              capture_o,
  output logic              done_o
);
  localparam int MAX_12 = (PRAND_PATS > SEMI_PATS) ? PRAND_PATS : SEMI_PATS;
  localparam int MAX_P  = (MAX_12 > DET_PATS) ? MAX_12 : DET_PATS;
  localparam int CNT_W  = $clog2(MAX_P + 1);

  phase_e phase_q, phase_d;
  step_e  step_q, step_d;
  logic   done_q, done_d;
  logic   shift_last, pat_last;
  logic   pat_inc, pat_clr;
  logic [CNT_W-1:0] pat_limit;

  // shift length tracking
  bist_bit_counter #(.SCAN_LEN(SCAN_LEN)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (step_q == ST_SHIFT),
    .shift_last (shift_last)
  );

  always_comb begin
    case (phase_q)
      PH_SEMI: pat_limit = CNT_W'(SEMI_PATS);
      PH_DET:  pat_limit = CNT_W'(DET_PATS);
      default: pat_limit = CNT_W'(PRAND_PATS);
    endcase
  end

  assign pat_inc = (step_q == ST_CAPT);
  assign pat_clr = (step_q == ST_CAPT) && pat_last;

  bist_pat_counter #(.CNT_W(CNT_W)) u_pats (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (pat_inc),
    .clr      (pat_clr),
    .limit    (pat_limit),
    .pat_last (pat_last)
  );

  bist_src_select #(.RESEED(RESEED)) u_sel (
    .phase      (phase_q),
    .sel_random (sel_random_o),
    .sel_flip   (sel_flip_o)
  );

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    done_d  = done_q;
    case (step_q)
      ST_IDLE: begin
        if (start_i) begin
          phase_d = PH_PRAND;
          step_d  = ST_SHIFT;
          done_d  = 1'b0;
        end
      end
      ST_SEED: begin
        if (seed_valid_i) step_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (shift_last) step_d = ST_CAPT;
      end
      ST_CAPT: begin
        if (pat_last) begin
          case (phase_q)
            PH_PRAND: begin
              phase_d = PH_SEMI;
              step_d  = ST_SHIFT;
            end
            PH_SEMI: begin
              phase_d = PH_DET;
              step_d  = RESEED ? ST_SEED : ST_SHIFT;
            end
            default: begin
              phase_d = PH_IDLE;
              step_d  = ST_IDLE;
              done_d  = 1'b1;
            end
          endcase
        end else begin
          step_d = (RESEED && phase_q == PH_DET) ? ST_SEED : ST_SHIFT;
        end
      end
      default: step_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  assign phase_o      = phase_q;
  assign scan_en_o    = (step_q == ST_SHIFT);
  assign last_shift_o = shift_last;
  assign capture_o    = (step_q == ST_CAPT);
  assign seed_ready_o = (step_q == ST_SEED);
  assign seed_load_o  = (step_q == ST_SEED) && seed_valid_i;
  assign seed_o       = seed_data_i;
  assign done_o       = done_q;

  // R7: capture lasts one cycle and only follows the final shift
  assert_capture_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |=> !capture_o);
  assert_capture_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_o) |-> $past(last_shift_o));
  // R8: a seed load is followed directly by shifting in phase 3
  assert_seed_then_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load_o |=> (scan_en_o && phase_o == 2'd3));
  // R2: phases only advance by one, or wrap from phase 3 to idle
  assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |->
      ((phase_o == $past(phase_o) + 2'd1) || ($past(phase_o) == 2'd3 && phase_o == 2'd0)));
  // R9: done holds until a start arrives
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
  // R10: a running session is not restarted
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 2'd0) |=> (phase_o != 2'd1 || $past(phase_o) == 2'd1));
endmodule

// File: tb/scan_bist_sequencer_bench.sv
module scan_bist_sequencer_bench;
  localparam int SL = 5;
  localparam int P1 = 3;
  localparam int P2 = 2;
  localparam int NS = 2;
  localparam int SW = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic start, start2;
  logic seed_valid;
  logic [SW-1:0] seed_data;
  logic seed_ready, seed_load;
  logic [SW-1:0] seed_out;
  logic [1:0] phase;
  logic sel_r, sel_f, scan_en, last_sh, capt, done;
  logic [1:0] phase2;
  logic sel_r2, sel_f2, scan_en2, last_sh2, capt2, done2;
  logic seed_ready2, seed_load2;
  logic [SW-1:0] seed_out2;

  always #4 clk = ~clk;

  scan_bist_sequencer #(.SCAN_LEN(SL), .PRAND_PATS(P1), .SEMI_PATS(P2),
    .DET_PATS(NS), .SEED_W(SW), .RESEED(1'b1)) u_scan_bist_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .seed_valid_i(seed_valid),
    .seed_data_i(seed_data), .seed_ready_o(seed_ready), .seed_load_o(seed_load),
    .seed_o(seed_out), .phase_o(phase), .sel_random_o(sel_r), .sel_flip_o(sel_f),
    .scan_en_o(scan_en), .last_shift_o(last_sh), .capture_o(capt), .done_o(done));

  scan_bist_sequencer #(.SCAN_LEN(SL), .PRAND_PATS(P1), .SEMI_PATS(P2),
    .DET_PATS(NS), .SEED_W(SW), .RESEED(1'b0)) u_scan_bist_sequencer_plain (
    .clk(clk), .rst_n(rst_n), .start_i(start2), .seed_valid_i(1'b0),
    .seed_data_i('0), .seed_ready_o(seed_ready2), .seed_load_o(seed_load2),
    .seed_o(seed_out2), .phase_o(phase2), .sel_random_o(sel_r2), .sel_flip_o(sel_f2),
    .scan_en_o(scan_en2), .last_shift_o(last_sh2), .capture_o(capt2), .done_o(done2));

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] exp_q[$];
  logic [SW-1:0] seed_q[$];
  int shift_cnt = 0;
  int plain_caps = 0;
  bit mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // driver side of the scoreboard: one item per expected capture
  task automatic push_session();
    for (int i = 0; i < P1; i++) exp_q.push_back({2'd1, 1'b0, 1'b0});
    for (int i = 0; i < P2; i++) exp_q.push_back({2'd2, 1'b1, 1'b0});
    for (int i = 0; i < NS; i++) exp_q.push_back({2'd3, 1'b0, 1'b0});
  endtask

  task automatic pulse_start();
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
  endtask

  task automatic feed_seeds(input int hold, input logic [SW-1:0] base);
    for (int k = 0; k < NS; k++) begin
      @(negedge clk);
      while (!seed_ready) @(negedge clk);
      for (int w = 0; w < hold; w++) begin
        @(negedge clk);
        check(!scan_en && !capt && seed_ready, "R8 stall", int'(scan_en), 0);
      end
      @(posedge clk); #2;
      seed_data = base + SW'(k * 7);
      seed_q.push_back(seed_data);
      seed_valid = 1'b1;
      @(posedge clk); #2 seed_valid = 1'b0;
    end
  endtask

  // monitor: samples on the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (scan_en) begin
        shift_cnt++;
        if (last_sh) check(shift_cnt == SL, "R6 last_shift position", shift_cnt, SL);
      end else if (last_sh) begin
        check(1'b0, "R6 last_shift without shift", 1, 0);
      end
      if (capt) begin
        logic [3:0] e;
        check(!scan_en, "R7 capture with shift", int'(scan_en), 0);
        check(shift_cnt == SL, "R6 shifts per pattern", shift_cnt, SL);
        shift_cnt = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2/R10 unexpected capture", int'(phase), 0);
        end else begin
          e = exp_q.pop_front();
          check(phase == e[3:2], "R2 phase order", int'(phase), int'(e[3:2]));
          check({sel_r, sel_f} == e[1:0], (e[3:2] == 2'd1) ? "R3 selects" :
                (e[3:2] == 2'd2) ? "R4 selects" : "R5 selects reseed",
                int'({sel_r, sel_f}), int'(e[1:0]));
        end
      end
      if (seed_load) begin
        check(phase == 2'd3, "R8 load phase", int'(phase), 3);
        if (seed_q.size() == 0) check(1'b0, "R8 unexpected load", 1, 0);
        else begin
          logic [SW-1:0] s;
          s = seed_q.pop_front();
          check(seed_out == s, "R8 seed value", int'(seed_out), int'(s));
        end
      end
      if (capt2) begin
        int ep;
        ep = (plain_caps < P1) ? 1 : (plain_caps < P1 + P2) ? 2 : 3;
        check(phase2 == 2'(ep), "R2 plain phase", int'(phase2), ep);
        if (ep == 3)
          check(sel_r2 && sel_f2, "R5 selects plain", int'({sel_r2, sel_f2}), 3);
        plain_caps++;
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start2 = 1'b0;
    seed_valid = 1'b0; seed_data = '0;
    repeat (2) @(negedge clk);
    check({phase, done, scan_en, capt, last_sh, seed_ready, seed_load, sel_r, sel_f} == '0,
          "R1 reset state", int'(phase), 0);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({phase, done, scan_en, capt, seed_ready, sel_r, sel_f} == '0,
          "R1 idle after reset", int'(phase), 0);
    mon_on = 1'b1;

    // session 1: prompt seeds, plain instance started alongside
    push_session();
    fork
      begin
        @(posedge clk); #2 begin start = 1'b1; start2 = 1'b1; end
        @(posedge clk); #2 begin start = 1'b0; start2 = 1'b0; end
      end
      feed_seeds(0, 20'h1A2B3);
    join
    @(negedge clk);
    while (!done) @(negedge clk);
    check(exp_q.size() == 0, "R2 all patterns seen", exp_q.size(), 0);
    check(phase == 2'd0, "R2 back to idle", int'(phase), 0);
    check(seed_q.size() == 0, "R8 one load per pattern", seed_q.size(), 0);
    check(done2, "R9 plain done", int'(done2), 1);
    check(plain_caps == P1 + P2 + NS, "R2 plain pattern total", plain_caps, P1 + P2 + NS);
    repeat (6) @(negedge clk);
    check(done, "R9 done held", int'(done), 1);
    check(!scan_en && !capt, "R9 quiet while done", int'(scan_en), 0);

    // session 2: delayed seeds and a stray start mid-run
    push_session();
    fork
      begin
        pulse_start();
        @(negedge clk);
        check(!done && phase == 2'd1, "R9 done cleared on start", int'(done), 0);
        repeat (7) @(posedge clk);
        pulse_start();
      end
      feed_seeds(4, 20'h0F0F0);
    join
    @(negedge clk);
    while (!done) @(negedge clk);
    check(exp_q.size() == 0, "R10 no restart", exp_q.size(), 0);
    check(seed_q.size() == 0, "R8 loads consumed", seed_q.size(), 0);
    repeat (4) @(negedge clk);
    check(done && phase == 2'd0, "R9 done after session 2", int'(done), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule